// File: doc/BRIEF.md
# Raster Framebuffer Scan Controller

The block owns the single port of a pixel memory that holds a 640×480 image of 16-bit colour words. Each colour word packs red in bits 15:11, green in bits 10:5 and blue in bits 4:0. It splits the port between two users. One is a raster scan that feeds the display timing logic one pixel per request. The other is a drawing client that writes single pixels at arbitrary (x, y) positions at any moment. A clear sequencer can also blank the whole frame to black through the same write path.

The display side raises `disp_req_i` in every cycle where it needs the next pixel. The scan read runs in that cycle, and one cycle later the colour appears on `pix_data_o` with `pix_valid_o`. It is tagged with start-of-frame at pixel (0,0) and end-of-line at the last column. The scan walks left to right and top to bottom, then wraps to (0,0) with no gap. Client writes go through a valid/ready handshake and take whatever memory cycles the scan leaves free. The memory address is a fixed base plus the offset `y·2^X_W + x`, with `X_W` = 10 by default, so no multiplier is needed. The memory returns read data one cycle after a read strobe.

Top module: `fb_scan_ctrl`

## Requirements
- R1: Every memory access drives `mem_addr_o` = `BASE_ADDR + y·2^X_W + x` for the pixel accessed, with x in the low `X_W` bits and y above them.
- R2: Scan reads visit the pixels in raster order, x rising within a row and rows from top to bottom. After pixel (H_PIX-1, V_PIX-1) the next read is pixel (0,0).
- R3: A cycle with `disp_req_i` high strobes `mem_re_o`. In the next cycle `pix_valid_o` is high and `pix_data_o` carries the memory word that was read. Without a request, `pix_valid_o` is low the next cycle.
- R4: `pix_sof_o` is high exactly with the pixel (0,0) output, and `pix_eol_o` is high exactly with pixels whose x = H_PIX-1.
- R5: In a cycle with `disp_req_i` high, `mem_we_o` and `wr_ready_o` are low.
- R6: A pending client write with `disp_req_i` low and no clear running sees `wr_ready_o` high. In that same cycle it writes `wr_color_i` unchanged to its address. A write held off by scan cycles completes in the first free cycle.
- R7: A client write with x ≥ H_PIX or y ≥ V_PIX is accepted, with `wr_ready_o` high, but never raises `mem_we_o`. Memory keeps its contents.
- R8: A pulse on `clr_req_i` while idle raises `clr_busy_o` the next cycle. The clear writes 0x0000 to every pixel in raster order, one in each cycle without `disp_req_i`. While it runs, `wr_ready_o` stays low.
- R9: In the cycle after the final clear write, `clr_done_o` is high for one cycle and `clr_busy_o` is low.
- R10: During reset `mem_we_o`, `mem_re_o`, `pix_valid_o`, `clr_busy_o` and `clr_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| disp_req_i | input | 1 | Display needs the next scan pixel this cycle |
| pix_valid_o | output | 1 | Scan pixel on output |
| pix_data_o | output | PIX_W | Scan pixel colour |
| pix_sof_o | output | 1 | Output pixel is (0,0) |
| pix_eol_o | output | 1 | Output pixel is last of its row |
| wr_valid_i | input | 1 | Client write pending |
| wr_ready_o | output | 1 | Client write taken this cycle |
| wr_x_i | input | X_W | Client column |
| wr_y_i | input | Y_W | Client row |
| wr_color_i | input | PIX_W | Client colour (5/6/5) |
| clr_req_i | input | 1 | Start a full-frame clear |
| clr_busy_o | output | 1 | Clear in progress |
| clr_done_o | output | 1 | Clear finished (one cycle) |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | PIX_W | Memory write data |
| mem_rdata_i | input | PIX_W | Memory read data, one cycle after the strobe |

## Verification
The bench aims at the boundary of the scan counter: the last pixel of a row must carry end-of-line, and the last pixel of the frame must wrap to (0,0) with start-of-frame. A design with an off-by-one there would shift whole rows or skip the origin. It holds a client write against several consecutive scan cycles. A design without scan priority would corrupt a read or emit a write in a read cycle, and one that forgot the held write would lose it. It also sends writes one step outside each edge. These must not alias into a wrapped pixel, which a design that only masked the fields would do. Finally it interleaves scan requests with a clear. Clear writes must skip scan cycles, still reach every pixel exactly once, and end with a single done pulse.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE   = 2'd0,
    SRC_SCAN   = 2'd1,
    SRC_CLEAR  = 2'd2,
    SRC_CLIENT = 2'd3
  } port_src_e;
endpackage

// File: rtl/fb_raster_cnt.sv
module fb_raster_cnt #(
  parameter int H_PIX = 640,
  parameter int V_PIX = 480,
  parameter int X_W   = 10,
  parameter int Y_W   = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           adv_i,
  output logic [X_W-1:0] x_o,
  output logic [Y_W-1:0] y_o,
  output logic           first_o,
  output logic           eol_o,
  output logic           last_o
);
  localparam logic [X_W-1:0] X_LAST = X_W'(H_PIX - 1);
  localparam logic [Y_W-1:0] Y_LAST = Y_W'(V_PIX - 1);

  assign first_o = (x_o == '0) && (y_o == '0);
  assign eol_o   = (x_o == X_LAST);
  assign last_o  = eol_o && (y_o == Y_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o <= '0;
      y_o <= '0;
    end else if (start_i) begin
      x_o <= '0;
      y_o <= '0;
    end else if (adv_i) begin
      if (eol_o) begin
        x_o <= '0;
        y_o <= last_o ? '0 : y_o + 1'b1;
      end else begin
        x_o <= x_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fb_clear_seq.sv
module fb_clear_seq #(
  parameter int H_PIX = 640,
  parameter int V_PIX = 480,
  parameter int X_W   = 10,
  parameter int Y_W   = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_req_i,
  input  logic           slot_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [X_W-1:0] x_o,
  output logic [Y_W-1:0] y_o
);
  logic start, step, last, first_unused, eol_unused;

  assign start = clr_req_i && !busy_o;
  assign step  = busy_o && slot_i;

  fb_raster_cnt #(.H_PIX(H_PIX), .V_PIX(V_PIX), .X_W(X_W), .Y_W(Y_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .adv_i   (step),
    .x_o     (x_o),
    .y_o     (y_o),
    .first_o (first_unused),
    .eol_o   (eol_unused),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= step && last;
      if (start)            busy_o <= 1'b1;
      else if (step && last) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fb_port_arb.sv
module fb_port_arb
  import fb_pkg::*;
#(
  parameter int H_PIX = 640,
  parameter int V_PIX = 480,
  parameter int X_W   = 10,
  parameter int Y_W   = 9,
  parameter int PIX_W = 16,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              scan_req_i,
  input  logic [X_W-1:0]    scan_x_i,
  input  logic [Y_W-1:0]    scan_y_i,
  input  logic              clr_busy_i,
  input  logic [X_W-1:0]    clr_x_i,
  input  logic [Y_W-1:0]    clr_y_i,
  input  logic              wr_valid_i,
  input  logic [X_W-1:0]    wr_x_i,
  input  logic [Y_W-1:0]    wr_y_i,
  input  logic [PIX_W-1:0]  wr_color_i,
  output logic              wr_ready_o,
  output logic              slot_free_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [PIX_W-1:0]  mem_wdata_o
);
  localparam int OFF_W = X_W + Y_W;
  localparam logic [X_W-1:0] X_LAST = X_W'(H_PIX - 1);
  localparam logic [Y_W-1:0] Y_LAST = Y_W'(V_PIX - 1);

  function automatic logic [ADDR_W-1:0] pix_addr(logic [X_W-1:0] x, logic [Y_W-1:0] y);
    logic [OFF_W-1:0] off;
    off = {y, x};
    return BASE_ADDR + ADDR_W'(off);
  endfunction

  port_src_e src;
  logic      in_range;

  assign in_range    = (wr_x_i <= X_LAST) && (wr_y_i <= Y_LAST);
  assign slot_free_o = !scan_req_i;
  assign wr_ready_o  = !scan_req_i && !clr_busy_i;

  always_comb begin
    if (scan_req_i)      src = SRC_SCAN;
    else if (clr_busy_i) src = SRC_CLEAR;
    else if (wr_valid_i) src = SRC_CLIENT;
    else                 src = SRC_IDLE;
  end

  always_comb begin
    mem_addr_o  = pix_addr(scan_x_i, scan_y_i);
    mem_re_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    unique case (src)
      SRC_SCAN: mem_re_o = 1'b1;
      SRC_CLEAR: begin
        mem_addr_o = pix_addr(clr_x_i, clr_y_i);
        mem_we_o   = 1'b1;
      end
      SRC_CLIENT: begin
        mem_addr_o  = pix_addr(wr_x_i, wr_y_i);
        mem_we_o    = in_range;
        mem_wdata_o = wr_color_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fb_scan_ctrl.sv
module fb_scan_ctrl #(
  parameter int H_PIX = 640,
  parameter int V_PIX = 480,
  parameter int X_W   = 10,
  parameter int Y_W   = 9,
  parameter int PIX_W = 16,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_req_i,
  output logic              pix_valid_o,
  output logic [PIX_W-1:0]  pix_data_o,
  output logic              pix_sof_o,
  output logic              pix_eol_o,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [X_W-1:0]    wr_x_i,
  input  logic [Y_W-1:0]    wr_y_i,
  input  logic [PIX_W-1:0]  wr_color_i,
  input  logic              clr_req_i,
  output logic              clr_busy_o,
  output logic              clr_done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [PIX_W-1:0]  mem_wdata_o,
  input  logic [PIX_W-1:0]  mem_rdata_i
);
  logic [X_W-1:0] scan_x, clr_x;
  logic [Y_W-1:0] scan_y, clr_y;
  logic scan_first, scan_eol, scan_last_unused, slot_free;

  fb_raster_cnt #(.H_PIX(H_PIX), .V_PIX(V_PIX), .X_W(X_W), .Y_W(Y_W)) u_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (1'b0),
    .adv_i   (disp_req_i),
    .x_o     (scan_x),
    .y_o     (scan_y),
    .first_o (scan_first),
    .eol_o   (scan_eol),
    .last_o  (scan_last_unused)
  );

  fb_clear_seq #(.H_PIX(H_PIX), .V_PIX(V_PIX), .X_W(X_W), .Y_W(Y_W)) u_clr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_req_i (clr_req_i),
    .slot_i    (slot_free),
    .busy_o    (clr_busy_o),
    .done_o    (clr_done_o),
    .x_o       (clr_x),
    .y_o       (clr_y)
  );

  fb_port_arb #(
    .H_PIX(H_PIX), .V_PIX(V_PIX), .X_W(X_W), .Y_W(Y_W),
    .PIX_W(PIX_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_arb (
    .scan_req_i  (disp_req_i),
    .scan_x_i    (scan_x),
    .scan_y_i    (scan_y),
    .clr_busy_i  (clr_busy_o),
    .clr_x_i     (clr_x),
    .clr_y_i     (clr_y),
    .wr_valid_i  (wr_valid_i),
    .wr_x_i      (wr_x_i),
    .wr_y_i      (wr_y_i),
    .wr_color_i  (wr_color_i),
    .wr_ready_o  (wr_ready_o),
    .slot_free_o (slot_free),
    .mem_addr_o  (mem_addr_o),
    .mem_re_o    (mem_re_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o)
  );

  // tags travel alongside the one-cycle memory read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o <= 1'b0;
      pix_sof_o   <= 1'b0;
      pix_eol_o   <= 1'b0;
    end else begin
      pix_valid_o <= disp_req_i;
      pix_sof_o   <= disp_req_i && scan_first;
      pix_eol_o   <= disp_req_i && scan_eol;
    end
  end

  assign pix_data_o = mem_rdata_i;
endmodule

// File: rtl/fb_scan_ctrl_chk.sv
module fb_scan_ctrl_chk #(
  parameter int PIX_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             disp_req_i,
  input logic             pix_valid_o,
  input logic             pix_sof_o,
  input logic             pix_eol_o,
  input logic             wr_ready_o,
  input logic             clr_busy_o,
  input logic             clr_done_o,
  input logic             mem_re_o,
  input logic             mem_we_o,
  input logic [PIX_W-1:0] mem_wdata_o
);
  a_r3_read_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_req_i |-> mem_re_o);
  a_r3_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_req_i |=> pix_valid_o);
  a_r3_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_req_i |=> !pix_valid_o);
  a_r4_tags_need_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_sof_o || pix_eol_o) |-> pix_valid_o);
  a_r5_scan_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_req_i |-> (!mem_we_o && !wr_ready_o));
  a_r8_client_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_busy_o |-> !wr_ready_o);
  a_r8_clear_black: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_busy_o && mem_we_o) |-> (mem_wdata_o == '0));
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_done_o |=> !clr_done_o);
  a_r9_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_done_o |-> !clr_busy_o);
  a_r10_port_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
endmodule

bind fb_scan_ctrl fb_scan_ctrl_chk #(.PIX_W(PIX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .disp_req_i  (disp_req_i),
  .pix_valid_o (pix_valid_o),
  .pix_sof_o   (pix_sof_o),
  .pix_eol_o   (pix_eol_o),
  .wr_ready_o  (wr_ready_o),
  .clr_busy_o  (clr_busy_o),
  .clr_done_o  (clr_done_o),
  .mem_re_o    (mem_re_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/sim_fb_scan_ctrl.sv
`timescale 1ns/1ps
module sim_fb_scan_ctrl;
  localparam int H = 12, V = 6, XW = 4, YW = 3, PW = 16, AW = 12;
  localparam int NPIX = H * V;
  localparam logic [AW-1:0] BASE = 12'h100;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic disp_req = 0, wr_valid = 0, clr_req = 0;
  logic [XW-1:0] wr_x = '0;
  logic [YW-1:0] wr_y = '0;
  logic [PW-1:0] wr_color = '0;
  logic pix_valid, pix_sof, pix_eol, wr_ready, clr_busy, clr_done, mem_re, mem_we;
  logic [PW-1:0] pix_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  logic [PW-1:0] mem  [128];
  logic [PW-1:0] gold [NPIX];
  int n_chk = 0, n_bad = 0, scan_pos = 0;
  bit dchk = 1;

  always #10 clk = ~clk;

  fb_scan_ctrl #(.H_PIX(H), .V_PIX(V), .X_W(XW), .Y_W(YW), .PIX_W(PW),
                 .ADDR_W(AW), .BASE_ADDR(BASE)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .disp_req_i(disp_req),
    .pix_valid_o(pix_valid), .pix_data_o(pix_data), .pix_sof_o(pix_sof), .pix_eol_o(pix_eol),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_x_i(wr_x), .wr_y_i(wr_y),
    .wr_color_i(wr_color), .clr_req_i(clr_req), .clr_busy_o(clr_busy), .clr_done_o(clr_done),
    .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata));

  always @(posedge clk) begin
    if (mem_we) mem[7'(mem_addr - BASE)] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[7'(mem_addr - BASE)];
  end

  function automatic logic [AW-1:0] exp_addr(int x, int y);
    return BASE + AW'(y * (1 << XW) + x);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: port checks before the edge, output checks after it
  task automatic step();
    bit req;
    int pos;
    req = disp_req;
    pos = scan_pos;
    #2;
    if (req) begin
      chk(mem_re === 1'b1, "R3", int'(mem_re), 1);
      chk(mem_addr === exp_addr(pos % H, pos / H), "R1/R2", int'(mem_addr), int'(exp_addr(pos % H, pos / H)));
      chk(mem_we === 1'b0 && wr_ready === 1'b0, "R5", int'({mem_we, wr_ready}), 0);
    end
    @(posedge clk); #1;
    if (req) begin
      chk(pix_valid === 1'b1, "R3", int'(pix_valid), 1);
      chk(pix_sof === (pos == 0), "R4", int'(pix_sof), int'(pos == 0));
      chk(pix_eol === (pos % H == H - 1), "R4", int'(pix_eol), int'(pos % H == H - 1));
      if (dchk) chk(pix_data === gold[pos], "R3", int'(pix_data), int'(gold[pos]));
      scan_pos = (pos + 1) % NPIX;
    end else begin
      chk(pix_valid === 1'b0, "R3", int'(pix_valid), 0);
    end
  endtask

  task automatic t_reset();
    rst_ni = 0;
    repeat (2) @(posedge clk);
    #1;
    chk({mem_we, mem_re, pix_valid, clr_busy, clr_done} === 5'b0, "R10",
        int'({mem_we, mem_re, pix_valid, clr_busy, clr_done}), 0);
    rst_ni = 1;
  endtask

  task automatic do_write(int x, int y, logic [PW-1:0] c, int hold);
    bit inr;
    inr = (x < H) && (y < V);
    wr_valid = 1; wr_x = XW'(x); wr_y = YW'(y); wr_color = c;
    for (int i = 0; i < hold; i++) begin
      disp_req = 1;
      step();
    end
    disp_req = 0;
    #1;
    chk(wr_ready === 1'b1, "R6", int'(wr_ready), 1);
    if (inr) begin
      chk(mem_we === 1'b1, "R6", int'(mem_we), 1);
      chk(mem_addr === exp_addr(x, y), "R1", int'(mem_addr), int'(exp_addr(x, y)));
      chk(mem_wdata === c, "R6", int'(mem_wdata), int'(c));
      gold[y * H + x] = c;
    end else begin
      chk(mem_we === 1'b0, "R7", int'(mem_we), 0);
    end
    step();
    wr_valid = 0;
  endtask

  task automatic t_frame(int n);
    disp_req = 1;
    for (int i = 0; i < n; i++) step();
    disp_req = 0;
  endtask

  task automatic t_clear();
    int cnt = 0;
    bit fin = 0;
    clr_req = 1;
    step();
    clr_req = 0;
    chk(clr_busy === 1'b1, "R8", int'(clr_busy), 1);
    dchk = 0;
    wr_valid = 1; wr_x = 4'd5; wr_y = 3'd1; wr_color = 16'h1234;
    for (int i = 0; i < 400 && !fin; i++) begin
      disp_req = (i % 3 == 1);
      #1;
      chk(wr_ready === 1'b0, "R8", int'(wr_ready), 0);
      if (!disp_req) begin
        chk(mem_we === 1'b1 && mem_wdata === '0, "R8", int'({mem_we, mem_wdata}), 'h10000);
        chk(mem_addr === exp_addr(cnt % H, cnt / H), "R8", int'(mem_addr), int'(exp_addr(cnt % H, cnt / H)));
        cnt++;
      end
      step();
      if (cnt == NPIX && !disp_req) begin
        chk(clr_done === 1'b1 && clr_busy === 1'b0, "R9", int'({clr_done, clr_busy}), 2);
        fin = 1;
      end else begin
        chk(clr_done === 1'b0, "R9", int'(clr_done), 0);
      end
    end
    chk(fin, "R8", cnt, NPIX);
    disp_req = 0;
    for (int i = 0; i < NPIX; i++) gold[i] = '0;
    do_write(5, 1, 16'h1234, 0);
    chk(clr_done === 1'b0, "R9", int'(clr_done), 0);
    dchk = 1;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 16'hA000 + 16'(i);
    for (int i = 0; i < NPIX; i++) gold[i] = 16'hA000 + 16'((i / H) * (1 << XW) + i % H);
    t_reset();
    @(posedge clk); #1;
    do_write(3, 2, 16'hF81F, 0);            // R1 R6: magenta 5/6/5
    do_write(H - 1, V - 1, 16'h07E0, 0);    // R1 corner
    do_write(0, 0, 16'h001F, 2);            // R5 R6 held by scan
    do_write(H, 1, 16'hFFFF, 0);            // R7 x out
    do_write(2, V, 16'hFFFF, 1);            // R7 y out
    do_write(7, 4, 16'h0841, 3);            // R5 R6
    t_frame(NPIX + 3);                      // R2 R3 R4 wrap
    t_frame(NPIX - 3);
    t_clear();                              // R8 R9
    t_frame(NPIX);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule